// File: doc/BRIEF.md
# Palette Colour Lookup Table with Byte-Wide Register Port

This block stores the colour palette of a display pipeline. Each of its 256 entries is 18 bits wide and holds three 6-bit channels: red, green and blue. A processor reaches the table through an 8-bit register port with four registers: a pixel mask, a read index, a write index and a data register. Each entry is spread over three successive data-register accesses in red, green, blue order. After each full entry, an internal pointer steps to the next entry.

On the pixel side, every cycle the block takes an 8-bit pixel code and ANDs it with the pixel mask. It uses the result to look up one entry and presents the entry as an 18-bit colour one clock later. A processor update goes into staging registers and reaches the table only when its blue byte arrives. The pixel stream therefore never sees a half-written colour.

Top module: `pal_dac`

## Requirements
- R1: After reset, the pixel mask reads 0xFF, both indices read 0, both component sequences start at red, every table entry is zero, and `pix_rgb` is zero.
- R2: Register selects on `cpu_sel` are: 0 is the pixel mask, 1 is the read index, 2 is the write index, 3 is data. A read of selects 0, 1 or 2 returns the current value of that register on `cpu_rdata` in the same cycle.
- R3: Three data writes load red, green and blue into the entry chosen by the write index. The entry `{red,green,blue}` appears on `pix_rgb` with red at bits 17:12, green at bits 11:6 and blue at bits 5:0.
- R4: Red and green data writes go only into staging registers. The addressed entry, and so `pix_rgb`, keeps its old value until the blue write.
- R5: A data write stores only the low 6 bits of `cpu_wdata`. A data read returns a 6-bit channel zero-extended to 8 bits.
- R6: After the blue write, the write index advances by one and wraps from 255 to 0.
- R7: Three data reads return red, green and blue of the entry chosen by the read index. After the blue read, the read index advances by one and wraps from 255 to 0.
- R8: A write to either index register restarts that pointer's component sequence at red.
- R9: The read pointer and the write pointer, each with its own component counter, advance independently. Data writes leave the read index unchanged, and data reads leave the write index unchanged.
- R10: The table is looked up with `pix_idx` ANDed with the pixel mask.
- R11: `pix_rgb` shows the looked-up entry one clock after `pix_idx` is applied. If a blue write commits an entry in the same cycle that the pixel side looks it up, the pixel side returns the entry's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 2 | Register select (0 mask, 1 read index, 2 write index, 3 data) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (advances the data sequence) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the current state |
| pix_idx | input | 8 | Pixel colour code |
| pix_rgb | output | 18 | Looked-up colour {red,green,blue} |

## Verification
The bench loads entries at low, middle and top indices, including a run that crosses index 255. This separates correct wrap-around from writes that overflow into a wrong entry. It interleaves read-pointer and write-pointer traffic, and it restarts sequences in mid-entry, which exposes pointers or counters that are shared or fail to reset. Pixel lookups run with several mask values, with data bytes that have their top two bits set, and at the moment of a blue commit. These show whether masking, truncation, staging and the one-cycle latency are right.

// File: rtl/pal_dac.sv
module pal_dac #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 6,
  parameter int BUS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cpu_sel,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  input  logic [BUS_W-1:0]    cpu_wdata,
  output logic [BUS_W-1:0]    cpu_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*CH_W-1:0]   pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = 3 * CH_W;
  localparam logic [1:0] S_MASK = 2'd0, S_RIDX = 2'd1, S_WIDX = 2'd2, S_DATA = 2'd3;

  logic [ENT_W-1:0] pal [DEPTH];
  logic [IDX_W-1:0] widx, ridx, mask, widx_inc, ridx_inc;
  logic [1:0]       wcmp, rcmp;
  logic [CH_W-1:0]  st_r, st_g, rd_ch;
  logic             wr_data, rd_data, wr_last, rd_last;

  assign wr_data  = cpu_wr && cpu_sel == S_DATA;
  assign rd_data  = cpu_rd && cpu_sel == S_DATA;
  assign wr_last  = wr_data && wcmp == 2'd2;
  assign rd_last  = rd_data && rcmp == 2'd2;
  assign widx_inc = widx + 1'b1;
  assign ridx_inc = ridx + 1'b1;

  always_comb begin
    case (rcmp)
      2'd0:    rd_ch = pal[ridx][3*CH_W-1:2*CH_W];
      2'd1:    rd_ch = pal[ridx][2*CH_W-1:CH_W];
      default: rd_ch = pal[ridx][CH_W-1:0];
    endcase
    case (cpu_sel)
      S_MASK:  cpu_rdata = BUS_W'(mask);
      S_RIDX:  cpu_rdata = BUS_W'(ridx);
      S_WIDX:  cpu_rdata = BUS_W'(widx);
      default: cpu_rdata = BUS_W'(rd_ch);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      widx <= '0;
      ridx <= '0;
      wcmp <= '0;
      rcmp <= '0;
      st_r <= '0;
      st_g <= '0;
      pix_rgb <= '0;
      for (int i = 0; i < DEPTH; i++) pal[i] <= '0;
    end else begin
      pix_rgb <= pal[pix_idx & mask];
      if (rd_data) begin
        rcmp <= rd_last ? 2'd0 : rcmp + 2'd1;
        if (rd_last) ridx <= ridx_inc;
      end
      if (cpu_wr) begin
        case (cpu_sel)
          S_MASK: mask <= cpu_wdata[IDX_W-1:0];
          S_RIDX: begin ridx <= cpu_wdata[IDX_W-1:0]; rcmp <= '0; end
          S_WIDX: begin widx <= cpu_wdata[IDX_W-1:0]; wcmp <= '0; end
          default: begin
            case (wcmp)
              2'd0: st_r <= cpu_wdata[CH_W-1:0];
              2'd1: st_g <= cpu_wdata[CH_W-1:0];
              default: begin
                pal[widx] <= {st_r, st_g, cpu_wdata[CH_W-1:0]};
                widx <= widx_inc;
              end
            endcase
            wcmp <= wr_last ? 2'd0 : wcmp + 2'd1;
          end
        endcase
      end
    end
  end

  // R8: component counters never leave red..blue
  a_r8_cmp_range: assert property (@(posedge clk) disable iff (!rst_n)
    wcmp != 2'd3 && rcmp != 2'd3);
  a_r8_wr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel == S_WIDX) |=> wcmp == 2'd0);
  a_r8_rd_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel == S_RIDX) |=> rcmp == 2'd0);
  a_r6_widx_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> widx == $past(widx_inc));
  a_r7_ridx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_last && !cpu_wr) |=> ridx == $past(ridx_inc));
  a_r9_rd_indep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !cpu_rd) |=> $stable(ridx) && $stable(rcmp));
  a_r9_wr_indep: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !cpu_wr) |=> $stable(widx) && $stable(wcmp));
  a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |-> cpu_rdata[BUS_W-1:CH_W] == '0);
endmodule

// File: tb/pal_dac_tb.sv
module pal_dac_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] cpu_sel = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = 0, pix_idx = 0;
  logic [7:0] cpu_rdata;
  logic [17:0] pix_rgb;
  int checks = 0, errors = 0;

  pal_dac u_dut (.clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_rd = 1; #2 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic load(logic [7:0] i, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    wr(2, i); wr(3, r); wr(3, g); wr(3, b);
  endtask

  task automatic pix(logic [7:0] p, output logic [17:0] c);
    @(negedge clk); pix_idx = p; @(negedge clk); c = pix_rgb;
  endtask

  function automatic logic [17:0] rgb(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    return {r[5:0], g[5:0], b[5:0]};
  endfunction

  task automatic t_reset();
    logic [7:0] d; logic [17:0] c;
    chk("R1 pix_rgb", pix_rgb, 0);
    rd(0, d); chk("R1 mask", d, 8'hff);
    rd(1, d); chk("R1 ridx", d, 0);
    rd(2, d); chk("R1 widx", d, 0);
    pix(8'h37, c); chk("R1 entry zero", c, 0);
  endtask

  task automatic t_load();
    logic [17:0] c; logic [7:0] d;
    load(8'h10, 8'h3f, 8'h15, 8'h2a);
    pix(8'h10, c); chk("R3 entry", c, rgb(8'h3f, 8'h15, 8'h2a));
    rd(2, d); chk("R6 widx step", d, 8'h11);
    load(8'h20, 8'hc5, 8'h83, 8'hff);
    pix(8'h20, c); chk("R5 low bits", c, rgb(8'h05, 8'h03, 8'h3f));
  endtask

  task automatic t_partial();
    logic [17:0] c;
    wr(2, 8'h10); wr(3, 8'h01); wr(3, 8'h02);
    pix(8'h10, c); chk("R4 staged hidden", c, rgb(8'h3f, 8'h15, 8'h2a));
    wr(3, 8'h03);
    pix(8'h10, c); chk("R4 committed", c, rgb(1, 2, 3));
  endtask

  task automatic t_wrap();
    logic [17:0] c; logic [7:0] d;
    wr(2, 8'hff);
    wr(3, 8'h11); wr(3, 8'h12); wr(3, 8'h13);
    wr(3, 8'h21); wr(3, 8'h22); wr(3, 8'h23);
    pix(8'hff, c); chk("R6 entry 255", c, rgb(8'h11, 8'h12, 8'h13));
    pix(8'h00, c); chk("R6 wrap to 0", c, rgb(8'h21, 8'h22, 8'h23));
    rd(2, d); chk("R6 widx after wrap", d, 8'h01);
  endtask

  task automatic t_read();
    logic [7:0] d;
    wr(1, 8'h10);
    rd(3, d); chk("R7 red", d, 1);
    rd(3, d); chk("R7 green", d, 2);
    rd(3, d); chk("R7 blue", d, 3);
    rd(1, d); chk("R7 ridx step", d, 8'h11);
    wr(1, 8'h20);
    rd(3, d); chk("R5 zero ext", d, 8'h05);
    wr(1, 8'hff); rd(3, d); rd(3, d); rd(3, d);
    rd(3, d); chk("R7 wrap red of 0", d, 8'h21);
    rd(1, d); chk("R7 ridx after wrap", d, 8'h00);
  endtask

  task automatic t_restart();
    logic [7:0] d; logic [17:0] c;
    wr(1, 8'h10); rd(3, d); rd(3, d);
    wr(1, 8'h10); rd(3, d); chk("R8 read restart", d, 1);
    wr(2, 8'h30); wr(3, 8'h09);
    wr(2, 8'h30); wr(3, 8'h0a); wr(3, 8'h0b); wr(3, 8'h0c);
    pix(8'h30, c); chk("R8 write restart", c, rgb(8'h0a, 8'h0b, 8'h0c));
  endtask

  task automatic t_indep();
    logic [7:0] d;
    wr(1, 8'h20); wr(2, 8'h40);
    rd(3, d); wr(3, 8'h31); rd(3, d); wr(3, 8'h32);
    chk("R9 green unaffected", d, 8'h03);
    rd(3, d); chk("R9 blue", d, 8'h3f);
    wr(3, 8'h33);
    rd(1, d); chk("R9 ridx", d, 8'h21);
    rd(2, d); chk("R9 widx", d, 8'h41);
  endtask

  task automatic t_mask();
    logic [17:0] c; logic [7:0] d;
    wr(0, 8'h0f); rd(0, d); chk("R2 mask read", d, 8'h0f);
    pix(8'hf0, c); chk("R10 mask to 0", c, rgb(8'h21, 8'h22, 8'h23));
    wr(0, 8'h30); pix(8'hff, c); chk("R10 mask to 0x30", c, rgb(8'h0a, 8'h0b, 8'h0c));
    wr(0, 8'hff);
  endtask

  task automatic t_latency();
    wr(2, 8'h50); wr(3, 8'h01); wr(3, 8'h02);
    @(negedge clk); pix_idx = 8'h40;
    @(negedge clk); cpu_sel = 3; cpu_wdata = 8'h07; cpu_wr = 1; pix_idx = 8'h50;
    chk("R11 one cycle", pix_rgb, rgb(8'h31, 8'h32, 8'h33));
    @(negedge clk); cpu_wr = 0;
    chk("R11 old on same cycle", pix_rgb, 0);
    @(negedge clk); chk("R11 new next", pix_rgb, rgb(1, 2, 7));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1;
        t_reset(); t_load(); t_partial(); t_wrap(); t_read();
        t_restart(); t_indep(); t_mask(); t_latency();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule